// File: doc/BRIEF.md
# Production-Test Reference Divider

This block produces the clocks that a clock-generator chip drives during its production test mode. In that mode the synthesizer is bypassed. Every output family is then derived from the reference input (a crystal or a tester clock) by a fixed ratio, so a tester can check each output against a frequency it already knows. The block holds three counters, dividing by 2, 3 and 4, all clocked by the same reference edge. An output selector picks between these divided clocks and the normal synthesized clocks, which arrive on input ports.

Test mode is decoded from the three-bit frequency-select code that was latched at power-on. The bus-family ratio in test mode also depends on the latched bus-select bit. Both inputs stay fixed after power-on, so the selector needs no glitch-free switchover. The divide-by-3 output keeps a 50% duty cycle by combining a rising-edge count state with a copy of it delayed by half a period.

Top module: `tmode_ref_divider`

## Requirements
- R1: Test mode is active only when `fsel` equals 3'b110 (bit 2 is the most significant). Every other code selects the normal clocks.
- R2: In test mode, `ref_out` and `apic_out` both follow `ref_clk` undivided.
- R3: In test mode, `cpu_out` and `mem_out` carry `ref_clk` divided by 2.
- R4: In test mode, `usb48_out` carries `ref_clk` divided by 2 and `fix24_out` carries it divided by 4. Each of these is high for the first half of its period.
- R5: In test mode, `bus_out` carries `ref_clk` divided by 4 when `bsel` is 1 and divided by 3 when `bsel` is 0.
- R6: The divide-by-3 clock is high for 1.5 reference cycles out of every 3. It rises on a rising edge and falls on the falling edge one and a half cycles later.
- R7: All divided clocks are low from the second reference cycle of reset onwards. They all rise together on the first rising edge of `ref_clk` after reset is released.
- R8: Outside test mode, each output equals its normal input. In test mode the normal inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock (crystal or tester) |
| rst_n | input | 1 | Synchronous active-low reset |
| fsel | input | 3 | Latched frequency-select code |
| bsel | input | 1 | Latched bus-select bit |
| norm_ref | input | 1 | Normal reference-family clock |
| norm_apic | input | 1 | Normal interrupt-controller clock |
| norm_cpu | input | 1 | Normal processor clock |
| norm_mem | input | 1 | Normal memory clock |
| norm_usb48 | input | 1 | Normal 48 MHz clock |
| norm_fix24 | input | 1 | Normal 24 MHz clock |
| norm_bus | input | 1 | Normal bus clock |
| ref_out | output | 1 | Reference / test reference output |
| apic_out | output | 1 | Interrupt-controller clock output |
| cpu_out | output | 1 | Processor clock output |
| mem_out | output | 1 | Memory clock output |
| usb48_out | output | 1 | 48 MHz output |
| fix24_out | output | 1 | 24 MHz output |
| bus_out | output | 1 | Bus clock output |

## Verification
The selector is combinational, so the reference and normal pass-through results are due in the same instant as their inputs. The divided clocks change with no added cycle on the reference rising edge; the divide-by-3 clock also changes on the falling edge. The bench therefore checks every output twice per reference cycle, two time units after each edge. It predicts each value from a count of the rising edges since reset was released and the phase within the cycle. The first reset cycle is excluded from the checks, because the falling-edge half of the divide-by-3 clock only clears at the next falling edge.

// File: rtl/tcd_pkg.sv
// Shared constants and types for the test-mode reference divider.
// Assumes the frequency-select code is latched elsewhere and stays static.
package tcd_pkg;
    localparam int FSEL_W = 3;
    localparam logic [FSEL_W-1:0] TEST_CODE = 3'b110;

    // The three divided versions of the reference clock.
    typedef struct packed {
        logic by2;
        logic by3;
        logic by4;
    } div_clks_t;
endpackage

// File: rtl/tcd_divider.sv
// Divides clk by N with a 50% duty cycle.
// Even N: a rising-edge counter whose lower half drives the output.
// Odd N: that same decode ORed with a copy taken on the falling edge.
// Assumes a synchronous active-low reset, which parks the count at its last
// state, so the output goes high on the first rising edge after release.
module tcd_divider #(
    parameter int N = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_o
);
    localparam int CW   = (N > 2) ? $clog2(N) : 1;
    localparam int HALF = N / 2;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt;
    logic          pos_hi;

    // Count 0..N-1 on the rising edge; reset parks the count at the last state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= LAST;
        else
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // High for the first HALF states of the period.
    always_comb pos_hi = (cnt < CW'(HALF));

    generate
        if (N % 2 == 1) begin : g_odd
            logic neg_hi;

            // Delay the decode by half a cycle to stretch the high time.
            always_ff @(negedge clk) begin
                if (!rst_n)
                    neg_hi <= 1'b0;
                else
                    neg_hi <= pos_hi;
            end

            // Combine the two phases into a 50% duty output.
            always_comb div_o = pos_hi | neg_hi;

            // R6: the falling-edge copy trails the rising-edge decode by half a cycle.
            assert_half_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
                neg_hi == pos_hi);
        end else begin : g_even
            // An even ratio needs only the count decode.
            always_comb div_o = pos_hi;
        end
    endgenerate

    // R6: the count never leaves its range.
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R7: a reset cycle leaves the divided output low.
    assert_reset_low_R7: assert property (@(posedge clk)
        !rst_n |=> (div_o == 1'b0));
endmodule

// File: rtl/tcd_outmux.sv
// Chooses, for each output, the test-derived clock or the normal clock.
// Assumes test_on and bsel are static after power-on, so no glitch-free
// switchover is provided.
module tcd_outmux
    import tcd_pkg::*;
(
    input  logic      test_on,
    input  logic      bsel,
    input  logic      ref_clk,
    input  div_clks_t divs,
    input  logic      norm_ref,
    input  logic      norm_apic,
    input  logic      norm_cpu,
    input  logic      norm_mem,
    input  logic      norm_usb48,
    input  logic      norm_fix24,
    input  logic      norm_bus,
    output logic      ref_out,
    output logic      apic_out,
    output logic      cpu_out,
    output logic      mem_out,
    output logic      usb48_out,
    output logic      fix24_out,
    output logic      bus_out
);
    logic bus_test;

    // The bus ratio in test mode follows the bus-select bit.
    always_comb bus_test = bsel ? divs.by4 : divs.by3;

    // Per-output source selection.
    always_comb begin
        ref_out   = test_on ? ref_clk   : norm_ref;
        apic_out  = test_on ? ref_clk   : norm_apic;
        cpu_out   = test_on ? divs.by2  : norm_cpu;
        mem_out   = test_on ? divs.by2  : norm_mem;
        usb48_out = test_on ? divs.by2  : norm_usb48;
        fix24_out = test_on ? divs.by4  : norm_fix24;
        bus_out   = test_on ? bus_test  : norm_bus;
    end
endmodule

// File: rtl/tmode_ref_divider.sv
// Top of the test-mode reference divider. Decodes test mode from the latched
// select code, runs the three dividers from the reference and selects the
// outputs. Assumes fsel and bsel come from power-on latches and do not change
// while the outputs are in use.
module tmode_ref_divider
    import tcd_pkg::*;
#(
    parameter int DIV_FAST = 2,
    parameter int DIV_ODD  = 3,
    parameter int DIV_SLOW = 4
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [FSEL_W-1:0] fsel,
    input  logic              bsel,
    input  logic              norm_ref,
    input  logic              norm_apic,
    input  logic              norm_cpu,
    input  logic              norm_mem,
    input  logic              norm_usb48,
    input  logic              norm_fix24,
    input  logic              norm_bus,
    output logic              ref_out,
    output logic              apic_out,
    output logic              cpu_out,
    output logic              mem_out,
    output logic              usb48_out,
    output logic              fix24_out,
    output logic              bus_out
);
    localparam int NDIV = 3;
    localparam int RATIOS [NDIV] = '{DIV_FAST, DIV_ODD, DIV_SLOW};

    logic            test_on;
    logic [NDIV-1:0] div_vec;
    div_clks_t       divs;

    // Test mode is one fixed select code.
    always_comb test_on = (fsel == TEST_CODE);

    // One divider per ratio, all reset to the same phase.
    generate
        for (genvar i = 0; i < NDIV; i++) begin : g_div
            tcd_divider #(.N(RATIOS[i])) u_div (
                .clk   (ref_clk),
                .rst_n (rst_n),
                .div_o (div_vec[i])
            );
        end
    endgenerate

    // Name the divided clocks.
    always_comb begin
        divs.by2 = div_vec[0];
        divs.by3 = div_vec[1];
        divs.by4 = div_vec[2];
    end

    tcd_outmux u_mux (
        .test_on    (test_on),
        .bsel       (bsel),
        .ref_clk    (ref_clk),
        .divs       (divs),
        .norm_ref   (norm_ref),
        .norm_apic  (norm_apic),
        .norm_cpu   (norm_cpu),
        .norm_mem   (norm_mem),
        .norm_usb48 (norm_usb48),
        .norm_fix24 (norm_fix24),
        .norm_bus   (norm_bus),
        .ref_out    (ref_out),
        .apic_out   (apic_out),
        .cpu_out    (cpu_out),
        .mem_out    (mem_out),
        .usb48_out  (usb48_out),
        .fix24_out  (fix24_out),
        .bus_out    (bus_out)
    );

    // R3: the processor and memory outputs share one clock in test mode.
    assert_cpu_mem_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        test_on |-> (cpu_out == mem_out));

    // R4: the 48 MHz output matches the processor output in test mode.
    assert_usb_cpu_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        test_on |-> (usb48_out == cpu_out));

    // R5: with bsel high, the bus and 24 MHz outputs share the divide-by-4 clock.
    assert_bus_slow_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (test_on && bsel) |-> (bus_out == fix24_out));
endmodule

// File: tb/tmode_ref_divider_bench.sv
module tmode_ref_divider_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fsel = 3'b110;
    logic       bsel = 1'b1;
    logic       norm_ref = 0, norm_apic = 0, norm_cpu = 0, norm_mem = 0;
    logic       norm_usb48 = 0, norm_fix24 = 0, norm_bus = 0;
    logic       ref_out, apic_out, cpu_out, mem_out, usb48_out, fix24_out, bus_out;

    int tests  = 0;
    int fails  = 0;
    int k      = 0;   // rising edges since reset release
    int rcount = 0;   // rising edges seen in reset
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmode_ref_divider u_tmode_ref_divider (
        .ref_clk(clk), .rst_n(rst_n), .fsel(fsel), .bsel(bsel),
        .norm_ref(norm_ref), .norm_apic(norm_apic), .norm_cpu(norm_cpu),
        .norm_mem(norm_mem), .norm_usb48(norm_usb48), .norm_fix24(norm_fix24),
        .norm_bus(norm_bus),
        .ref_out(ref_out), .apic_out(apic_out), .cpu_out(cpu_out),
        .mem_out(mem_out), .usb48_out(usb48_out), .fix24_out(fix24_out),
        .bus_out(bus_out)
    );

    // Reference model state: edge counts.
    always @(posedge clk) begin
        if (rst_n) begin
            k      <= k + 1;
            rcount <= 0;
        end else begin
            k      <= 0;
            rcount <= rcount + 1;
        end
    end

    // Ideal divide-by-n waveform: 50% duty, high from the first rising edge.
    function automatic logic exp_div(int n, int kk, bit hi);
        int m;
        if (kk <= 0) return 1'b0;
        m = (kk - 1) % n;
        if (n % 2 == 0) return (m < n / 2);
        return hi ? (m <= n / 2) : (m < n / 2);
    endfunction

    task automatic chk(string tag, string name, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b (k=%0d t=%0t)", tag, name, act, exp, k, $time);
        end
    endtask

    task automatic compare_all(bit hi);
        bit    test;
        string dtag;
        logic  clkv;
        if (rcount == 1) return;
        test = (fsel == 3'b110);
        clkv = hi;
        if (!test) begin
            chk("R1 R8", "ref_out",   ref_out,   norm_ref);
            chk("R1 R8", "apic_out",  apic_out,  norm_apic);
            chk("R1 R8", "cpu_out",   cpu_out,   norm_cpu);
            chk("R1 R8", "mem_out",   mem_out,   norm_mem);
            chk("R1 R8", "usb48_out", usb48_out, norm_usb48);
            chk("R1 R8", "fix24_out", fix24_out, norm_fix24);
            chk("R1 R8", "bus_out",   bus_out,   norm_bus);
            return;
        end
        dtag = (k <= 1) ? "R7 " : "";
        chk("R2 R8", "ref_out",  ref_out,  clkv);
        chk("R2 R8", "apic_out", apic_out, clkv);
        chk({dtag, "R3"}, "cpu_out",   cpu_out,   exp_div(2, k, hi));
        chk({dtag, "R3"}, "mem_out",   mem_out,   exp_div(2, k, hi));
        chk({dtag, "R4"}, "usb48_out", usb48_out, exp_div(2, k, hi));
        chk({dtag, "R4"}, "fix24_out", fix24_out, exp_div(4, k, hi));
        if (bsel)
            chk({dtag, "R5"}, "bus_out", bus_out, exp_div(4, k, hi));
        else
            chk({dtag, "R5 R6"}, "bus_out", bus_out, exp_div(3, k, hi));
    endtask

    // Checks two units after each edge; new normal-input values at falling edge + 3.
    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2 compare_all(1'b1);
            @(negedge clk); #2 compare_all(1'b0);
            #1;
            {norm_ref, norm_apic, norm_cpu, norm_mem} = 4'($urandom);
            {norm_usb48, norm_fix24, norm_bus}        = 3'($urandom);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R7: reset state, test mode, bus at divide-by-4.
        @(negedge clk); #3;
        run_cycles(4);
        rst_n = 1'b1;
        // R7/R3/R4/R5: aligned start and divided waveforms.
        run_cycles(24);
        // R5 R6: bus at divide-by-3.
        bsel = 1'b0;
        run_cycles(30);
        // R1 R8: codes that are not test mode pass the normal clocks.
        fsel = 3'b111; run_cycles(10);
        fsel = 3'b010; run_cycles(10);
        fsel = 3'b100; run_cycles(6);
        fsel = 3'b000; run_cycles(6);
        // Back to test mode; dividers kept running throughout.
        fsel = 3'b110; run_cycles(12);
        // R7: reset mid-run, then realignment.
        rst_n = 1'b0;
        run_cycles(3);
        rst_n = 1'b1;
        run_cycles(15);
        bsel = 1'b1;
        run_cycles(12);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule